// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This block connects a core's load/store path to a 32-bit data memory that is addressed by word and written through per-byte enables. It forms the effective byte address from a base register and a 16-bit signed offset. It then uses the two low address bits and the access size to route data between the core's register format and the memory's byte lanes.

On a store, the low byte, the low halfword or the whole source value is copied onto every lane it could occupy. A byte enable mask then picks the lane or lanes that the memory writes. On a load, the addressed lanes are taken from the returned word and widened to 32 bits. The widening uses sign extension or zero extension, chosen by the unsigned flag. Lanes are big-endian: address offset 0 is bits 31:24.

The block is purely combinational. The core registers the effective address and the enables. It also registers the steered data and then presents them to memory. The returned word comes back through `mem_rdata_i` in a later cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: `addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32.
- R2: `size_i` encodes 00 = byte, 01 = halfword, 10 and 11 = word. `is_store_i` = 1 selects a store and 0 selects a load.
- R3: For stores, `wdata_o` holds the low byte of `store_data_i` copied into all four lanes for a byte, the low halfword copied into both halves for a halfword, and `store_data_i` unchanged for a word.
- R4: A byte load returns lane k = `addr_o[1:0]` (big-endian: k=0 is bits 31:24, k=3 is bits 7:0). The result is sign-extended when `unsigned_i` = 0 and zero-extended when `unsigned_i` = 1.
- R5: A halfword load at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0. The result is sign-extended when `unsigned_i` = 0 and zero-extended when `unsigned_i` = 1.
- R6: An aligned word load returns `mem_rdata_i` unchanged.
- R7: A halfword access with `addr_o[0]` = 1, or a word access with `addr_o[1:0]` != 0, sets `misaligned_o`. That access drives `byte_en_o` = 0000, and a load returns 0.
- R8: `byte_en_o` bit 3 enables bits 31:24. An aligned store enables one lane for a byte (4'b1000 >> k), two adjacent lanes for a halfword (1100 or 0011), and all four lanes for a word. A load drives 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend load result |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| store_data_i | input | 32 | Source register for stores |
| mem_rdata_i | input | 32 | Word returned by memory |
| addr_o | output | 32 | Effective byte address |
| byte_en_o | output | 4 | Per-lane write enables |
| wdata_o | output | 32 | Lane-steered store data |
| load_data_o | output | 32 | Aligned, extended load result |
| misaligned_o | output | 1 | Access not naturally aligned |

## Verification
The checker evaluates the following rules whenever an input changes:
- A misaligned access drives no byte enables.
- Store enables have the allowed shapes, and loads drive no enables.
- The upper bits of every byte or halfword load are a pure zero or sign fill of the selected field.

Some properties depend on the actual values rather than their shape. These are the lane that an address offset picks, the address sum when the offset is negative and when the addition wraps, and the exact replicated store pattern. Only the bench's scenarios, with values computed in advance, can show them.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_add.sv
module lsu_ea_add #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  assign addr_o  = base_i + off_ext;
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [LSB_W-1:0]  lane_i,
  input  logic              misaligned_i,
  input  logic              is_store_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  byte_en_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [LANES-1:0] TOP1 = LANES'(1) << (LANES - 1);
  localparam logic [LANES-1:0] TOP2 = LANES'(3) << (LANES - 2);

  logic [LANES-1:0] mask;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        wdata_o = {LANES{data_i[7:0]}};
        mask    = TOP1 >> lane_i;
      end
      SZ_HALF: begin
        wdata_o = {2{data_i[HALF_W-1:0]}};
        mask    = TOP2 >> lane_i;
      end
      default: begin
        wdata_o = data_i;
        mask    = '1;
      end
    endcase
  end

  assign byte_en_o = (is_store_i && !misaligned_i) ? mask : '0;
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [LSB_W-1:0]  lane_i,
  input  logic              unsigned_i,
  input  logic              misaligned_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] load_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] byte_sh, half_sh;
  logic [7:0]        byte_v;
  logic [HALF_W-1:0] half_v;

  // big-endian: lane 0 is the most significant byte
  assign byte_sh = rdata_i >> (8 * (LANES - 1 - int'(lane_i)));
  assign half_sh = rdata_i >> (8 * (LANES - 2 - int'(lane_i)));
  assign byte_v  = byte_sh[7:0];
  assign half_v  = half_sh[HALF_W-1:0];

  always_comb begin
    if (misaligned_i) begin
      load_o = '0;
    end else begin
      unique case (acc_size_e'(size_i))
        SZ_BYTE: load_o = {{(DATA_W-8){~unsigned_i & byte_v[7]}}, byte_v};
        SZ_HALF: load_o = {{HALF_W{~unsigned_i & half_v[HALF_W-1]}}, half_v};
        default: load_o = rdata_i;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LSB_W = $clog2(LANES)
) (
  input  logic              is_store_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [LANES-1:0]  byte_en_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              misaligned_o
);
  logic [LSB_W-1:0] lane;

  lsu_ea_add #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_ea (
    .base_i  (base_i),
    .offset_i(offset_i),
    .addr_o  (addr_o)
  );

  assign lane = addr_o[LSB_W-1:0];

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: misaligned_o = 1'b0;
      SZ_HALF: misaligned_o = lane[0];
      default: misaligned_o = |lane;
    endcase
  end

  lsu_store_steer #(.DATA_W(DATA_W)) u_st (
    .size_i      (size_i),
    .lane_i      (lane),
    .misaligned_i(misaligned_o),
    .is_store_i  (is_store_i),
    .data_i      (store_data_i),
    .wdata_o     (wdata_o),
    .byte_en_o   (byte_en_o)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i      (size_i),
    .lane_i      (lane),
    .unsigned_i  (unsigned_i),
    .misaligned_i(misaligned_o),
    .rdata_i     (mem_rdata_i),
    .load_o      (load_data_o)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        is_store_i,
  input logic [1:0]  size_i,
  input logic        unsigned_i,
  input logic [31:0] load_data_o,
  input logic [3:0]  byte_en_o,
  input logic        misaligned_o
);
  always_comb begin
    // R7
    if (misaligned_o)
      a_r7_mis_no_be: assert (byte_en_o == 4'b0000) else $error("R7 enables on misaligned");
    // R8
    if (!is_store_i)
      a_r8_load_no_be: assert (byte_en_o == 4'b0000) else $error("R8 load enables");
    if (is_store_i && !misaligned_o)
      a_r8_be_shape: assert (byte_en_o == 4'b1111 || byte_en_o == 4'b1100 ||
                             byte_en_o == 4'b0011 || $countones(byte_en_o) == 1)
        else $error("R8 bad enable shape");
    // R4
    if (!is_store_i && size_i == 2'b00)
      a_r4_byte_fill: assert (load_data_o[31:8] == (unsigned_i ? 24'h0 : {24{load_data_o[7]}}))
        else $error("R4 bad byte fill");
    // R5
    if (!is_store_i && size_i == 2'b01 && !misaligned_o)
      a_r5_half_fill: assert (load_data_o[31:16] == (unsigned_i ? 16'h0 : {16{load_data_o[15]}}))
        else $error("R5 bad half fill");
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .is_store_i  (is_store_i),
  .size_i      (size_i),
  .unsigned_i  (unsigned_i),
  .load_data_o (load_data_o),
  .byte_en_o   (byte_en_o),
  .misaligned_o(misaligned_o)
);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic        clk = 1'b0;
  logic        is_store, uns;
  logic [1:0]  size;
  logic [31:0] base, sdata, rdata;
  logic [15:0] off;
  logic [31:0] addr, wdata, ldata;
  logic [3:0]  be;
  logic        mis;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lsu_lane_align u_lsu_lane_align (
    .is_store_i(is_store), .size_i(size), .unsigned_i(uns),
    .base_i(base), .offset_i(off), .store_data_i(sdata), .mem_rdata_i(rdata),
    .addr_o(addr), .byte_en_o(be), .wdata_o(wdata), .load_data_o(ldata),
    .misaligned_o(mis)
  );

  // st, size, uns, base, off, exp_addr, exp_be, exp_wdata, exp_load, exp_mis
  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        un;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] ea;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ld;
    logic        mis;
  } vec_t;

  localparam logic [31:0] SD = 32'h1234_56F0;
  localparam logic [31:0] RD = 32'h8A7B_C4D5;
  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'b00, 1'b0, 32'h1000, 16'h0000, 32'h1000, 4'b0000, 32'h0, 32'hFFFF_FF8A, 1'b0},
    '{1'b0, 2'b00, 1'b1, 32'h1000, 16'h0003, 32'h1003, 4'b0000, 32'h0, 32'h0000_00D5, 1'b0},
    '{1'b0, 2'b00, 1'b0, 32'h1000, 16'h0002, 32'h1002, 4'b0000, 32'h0, 32'hFFFF_FFC4, 1'b0},
    '{1'b0, 2'b00, 1'b0, 32'h1000, 16'h0001, 32'h1001, 4'b0000, 32'h0, 32'h0000_007B, 1'b0},
    '{1'b0, 2'b01, 1'b0, 32'h2000, 16'hFFFE, 32'h1FFE, 4'b0000, 32'h0, 32'hFFFF_C4D5, 1'b0},
    '{1'b0, 2'b01, 1'b1, 32'h2000, 16'h0000, 32'h2000, 4'b0000, 32'h0, 32'h0000_8A7B, 1'b0},
    '{1'b0, 2'b01, 1'b0, 32'h2000, 16'hFFFC, 32'h1FFC, 4'b0000, 32'h0, 32'hFFFF_8A7B, 1'b0},
    '{1'b0, 2'b10, 1'b0, 32'h3000, 16'h0004, 32'h3004, 4'b0000, 32'h0, RD,            1'b0},
    '{1'b0, 2'b01, 1'b0, 32'h3000, 16'h0001, 32'h3001, 4'b0000, 32'h0, 32'h0,         1'b1},
    '{1'b1, 2'b00, 1'b0, 32'h4000, 16'h0001, 32'h4001, 4'b0100, 32'hF0F0_F0F0, 32'h0, 1'b0},
    '{1'b1, 2'b00, 1'b0, 32'h4000, 16'h0003, 32'h4003, 4'b0001, 32'hF0F0_F0F0, 32'h0, 1'b0},
    '{1'b1, 2'b01, 1'b0, 32'h4000, 16'h0002, 32'h4002, 4'b0011, 32'h56F0_56F0, 32'h0, 1'b0},
    '{1'b1, 2'b01, 1'b0, 32'h4000, 16'h0000, 32'h4000, 4'b1100, 32'h56F0_56F0, 32'h0, 1'b0},
    '{1'b1, 2'b10, 1'b0, 32'h4000, 16'h0000, 32'h4000, 4'b1111, SD,            32'h0, 1'b0},
    '{1'b1, 2'b10, 1'b0, 32'h4000, 16'h0002, 32'h4002, 4'b0000, SD,            32'h0, 1'b1},
    '{1'b1, 2'b01, 1'b0, 32'h4000, 16'h0003, 32'h4003, 4'b0000, 32'h56F0_56F0, 32'h0, 1'b1},
    '{1'b0, 2'b00, 1'b1, 32'hFFFF_FFFE, 16'h0003, 32'h0000_0001, 4'b0000, 32'h0, 32'h0000_007B, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic un,
                       input logic [31:0] b, input logic [15:0] o);
    @(negedge clk);
    is_store = st; size = sz; uns = un; base = b; off = o;
    #1;
  endtask

  initial begin
    is_store = 1'b0; size = 2'b00; uns = 1'b0; base = '0; off = '0;
    sdata = SD; rdata = RD;
    repeat (2) @(negedge clk);
    #1;
    // idle state: zero address, load of lane 0
    chk("R1", "idle addr", addr, 32'h0);
    chk("R8", "idle be", {28'h0, be}, 32'h0);
    chk("R4", "idle load", ldata, 32'hFFFF_FF8A);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].st, VT[i].sz, VT[i].un, VT[i].base, VT[i].off);
      chk("R1", $sformatf("v%0d addr", i), addr, VT[i].ea);
      chk(VT[i].mis ? "R7" : "R8", $sformatf("v%0d be", i), {28'h0, be}, {28'h0, VT[i].be});
      chk("R7", $sformatf("v%0d mis", i), {31'h0, mis}, {31'h0, VT[i].mis});
      if (VT[i].st)
        chk("R3", $sformatf("v%0d wdata", i), wdata, VT[i].wd);
      else
        chk(VT[i].sz == 2'b00 ? "R4" : (VT[i].sz == 2'b01 ? "R5" : "R6"),
            $sformatf("v%0d load", i), ldata, VT[i].ld);
    end

    // R2: code 11 behaves as word for load and store
    drive(1'b0, 2'b11, 1'b0, 32'h5000, 16'h0000);
    chk("R2", "size11 load", ldata, RD);
    drive(1'b1, 2'b11, 1'b0, 32'h5000, 16'h0000);
    chk("R2", "size11 be", {28'h0, be}, 32'hF);
    chk("R2", "size11 wdata", wdata, SD);
    drive(1'b1, 2'b11, 1'b0, 32'h5000, 16'h0001);
    chk("R7", "size11 mis", {31'h0, mis}, 32'h1);

    // R6: word load of a second pattern, unsigned flag has no effect
    rdata = 32'h0000_FF01;
    drive(1'b0, 2'b10, 1'b1, 32'h6000, 16'h0008);
    chk("R6", "word load uns", ldata, 32'h0000_FF01);
    // R5: unsigned half of a negative value
    rdata = 32'hFFFF_8001;
    drive(1'b0, 2'b01, 1'b1, 32'h6000, 16'h0002);
    chk("R5", "half zext", ldata, 32'h0000_8001);
    // R1: most negative offset
    drive(1'b0, 2'b10, 1'b0, 32'h0001_0000, 16'h8000);
    chk("R1", "min offset", addr, 32'h0000_8000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule